// File: doc/BRIEF.md
# Hashed Page Table Walker

This block finds the page table entry that translates a 32-bit effective address by searching a hashed table held in memory. A single start pulse supplies the effective address, the segment register already chosen by the top four address bits, a store/non-store flag, and the table base and size mask. The walker then reads entries over a simple request/acknowledge memory port, one 32-bit word at a time. The entry it finds is returned together with the entry's address and the physical address. If no entry matches, the walker reports a miss.

The search covers two groups of eight 8-byte entries. The first group is chosen by a primary hash of the segment ID and the page index. The second group is chosen by the bitwise complement of that hash and is searched only when the first group has no match. On a hit, the walker sets the referenced bit in the entry's second word, and also sets the changed bit for a store. It writes that word back only when the new value differs from the old one. Checking the access rights and loading a TLB are left to the logic downstream.

Top module: `hpt_walker`

## Requirements
- R1: The segment ID is seg_reg[23:0] and the page index is ea[27:12]. The primary hash is the segment ID XOR the zero-extended page index. The group address is tbl_base + ((hash << 6) & tbl_mask).
- R2: The secondary hash is the 32-bit complement of the primary hash. It is turned into a group address with the same formula.
- R3: Within a group, entry first words are read at group+0, +8, +16 and so on, in increasing order. The second word of an entry, at entry+4, is read only after that entry's first word has matched. The first matching entry ends the search.
- R4: A first word w0 matches when all of these hold: w0[31] (valid) is 1; w0[6] (hash select) equals the pass (0 for primary, 1 for secondary); w0[30:7] equals the segment ID; and w0[5:0] equals ea[27:22].
- R5: The secondary group is searched only after all eight primary entries fail. A miss (done with hit=0) is reported only after all sixteen first words have been read.
- R6: On a hit, the returned second word pte_lo has bit 8 (referenced) set. For a store, bit 7 (changed) is set as well. All other bits keep their value from memory.
- R7: The second word is written back to entry+4 exactly once if the update changed its value, and is not written at all if the value is unchanged.
- R8: On a hit, phys_addr = {pte_lo[31:12], ea[11:0]}, pte_addr is the address of the entry's first word, and pte_hi is that first word.
- R9: wr_keep is 1 after a hit by a store and 0 after a hit by a non-store, so that a later store walks again and sets the changed bit.
- R10: mem_req, mem_addr, mem_we and mem_wdata stay stable from the moment a request is raised until mem_ack. Only one request is outstanding at a time.
- R11: After reset, done and mem_req are 0. done is a single-cycle pulse, and the results stay stable until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a walk (taken when idle) |
| seg_reg | input | 32 | Segment register for the address |
| ea | input | 32 | Effective address |
| is_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Byte address of the table |
| tbl_mask | input | 32 | Mask applied to the group byte offset |
| mem_req | output | 1 | Memory request, held until ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| hit | output | 1 | Entry found |
| pte_hi | output | 32 | First word of the entry found |
| pte_lo | output | 32 | Second word with updated bits |
| pte_addr | output | 32 | Address of the entry found |
| phys_addr | output | 32 | Translated physical address |
| wr_keep | output | 1 | Write right kept for the caller |

## Verification
The interesting collision is between a match on the last entry of the primary group and the rollover that would start the secondary pass. Both are decided on the same acknowledge. The bench places a matching entry in primary slot 7 and a second, also valid, match in the secondary group. It expects the primary entry and exactly eight first-word reads. A related case covers the referenced/changed update when it leaves the word unchanged: that must end the walk with no write cycle. The bench provokes it with entries that already have the bits set, and judges it by counting write transactions at the port.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W    = 32;
  localparam int SID_W     = 24;
  localparam int PIDX_LSB  = 12;
  localparam int PIDX_W    = 16;
  localparam int ABBR_W    = 6;
  localparam int B_VALID   = 31;
  localparam int B_HSEL    = 6;
  localparam int B_REF     = 8;
  localparam int B_CHG     = 7;

  typedef enum logic [2:0] {
    W_IDLE, W_RD_HI, W_RD_LO, W_WBACK, W_FIN
  } walk_state_t;

  // Primary hash, or its complement for the secondary pass.
  function automatic logic [WORD_W-1:0] grp_hash(
    input logic [WORD_W-1:0] seg, input logic [WORD_W-1:0] addr, input logic sec);
    logic [WORD_W-1:0] h;
    h = {{(WORD_W-SID_W){1'b0}},
         seg[SID_W-1:0] ^ {{(SID_W-PIDX_W){1'b0}}, addr[PIDX_LSB+PIDX_W-1:PIDX_LSB]}};
    return sec ? ~h : h;
  endfunction

  // Sets referenced, plus changed for stores.
  function automatic logic [WORD_W-1:0] rc_update(
    input logic [WORD_W-1:0] w1, input logic st);
    logic [WORD_W-1:0] r;
    r = w1;
    r[B_REF] = 1'b1;
    if (st) r[B_CHG] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] seg,
  input  logic [WORD_W-1:0] addr,
  input  logic              sec,
  output logic              match
);
  logic sid_eq, abbr_eq;
  assign sid_eq  = (w0[B_VALID-1:B_HSEL+1] == seg[SID_W-1:0]);
  assign abbr_eq = (w0[ABBR_W-1:0] == addr[PIDX_LSB+PIDX_W-1:PIDX_LSB+PIDX_W-ABBR_W]);
  assign match   = w0[B_VALID] && (w0[B_HSEL] == sec) && sid_eq && abbr_eq;
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int GRP_ENTRIES = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [WORD_W-1:0] seg,
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] ent_addr,
  output logic              at_last,
  output logic              sec_pass,
  output logic              exhausted
);
  localparam int IDX_W     = $clog2(GRP_ENTRIES);
  localparam int GRP_SHIFT = $clog2(GRP_ENTRIES * ENTRY_BYTES);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] grp_base;

  assign grp_base  = base + ((grp_hash(seg, addr, sec_pass) << GRP_SHIFT) & mask);
  assign ent_addr  = grp_base + WORD_W'(idx) * WORD_W'(ENTRY_BYTES);
  assign at_last   = (idx == IDX_W'(GRP_ENTRIES - 1));
  assign exhausted = at_last && sec_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      sec_pass <= 1'b0;
    end else if (load) begin
      idx      <= '0;
      sec_pass <= 1'b0;
    end else if (advance) begin
      if (at_last) begin
        idx      <= '0;
        sec_pass <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R3: a step inside a group moves exactly one entry up
  a_r3_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_last && !load) |=> (ent_addr == $past(ent_addr) + WORD_W'(ENTRY_BYTES)));
  // R5: the secondary pass begins only after the last primary slot
  a_r5_pass_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_pass) |-> ($past(at_last) && $past(advance)));
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int GRP_ENTRIES = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] seg_reg,
  input  logic [31:0] ea,
  input  logic        is_store,
  input  logic [31:0] tbl_base,
  input  logic [31:0] tbl_mask,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        hit,
  output logic [31:0] pte_hi,
  output logic [31:0] pte_lo,
  output logic [31:0] pte_addr,
  output logic [31:0] phys_addr,
  output logic        wr_keep
);
  localparam int LO_OFS = ENTRY_BYTES / 2;

  walk_state_t st;
  logic [31:0] seg_q, ea_q, base_q, mask_q, w0_q, w1_q, addr_q, w1_new;
  logic        store_q, hit_q;
  logic        start_acc, adv, ent_match, at_last, sec_pass, exhausted;
  logic [31:0] ent_addr;
  logic        rd_hi_ack, rd_lo_ack, wb_ack;

  assign start_acc = (st == W_IDLE) && start;
  assign rd_hi_ack = (st == W_RD_HI) && mem_ack;
  assign rd_lo_ack = (st == W_RD_LO) && mem_ack;
  assign wb_ack    = (st == W_WBACK) && mem_ack;
  assign adv       = rd_hi_ack && !ent_match && !exhausted;
  assign w1_new    = rc_update(mem_rdata, store_q);

  hpt_addr_gen #(.GRP_ENTRIES(GRP_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)) u_agen (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .advance(adv),
    .seg(seg_q), .addr(ea_q), .base(base_q), .mask(mask_q),
    .ent_addr(ent_addr), .at_last(at_last), .sec_pass(sec_pass),
    .exhausted(exhausted));

  hpt_match u_match (
    .w0(mem_rdata), .seg(seg_q), .addr(ea_q), .sec(sec_pass), .match(ent_match));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      seg_q   <= '0;
      ea_q    <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      store_q <= 1'b0;
      hit_q   <= 1'b0;
      w0_q    <= '0;
      w1_q    <= '0;
      addr_q  <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          seg_q   <= seg_reg;
          ea_q    <= ea;
          base_q  <= tbl_base;
          mask_q  <= tbl_mask;
          store_q <= is_store;
          hit_q   <= 1'b0;
          st      <= W_RD_HI;
        end
        W_RD_HI: if (mem_ack) begin
          w0_q <= mem_rdata;
          if (ent_match) begin
            addr_q <= ent_addr;
            st     <= W_RD_LO;
          end else if (exhausted) begin
            st <= W_FIN;
          end
        end
        W_RD_LO: if (mem_ack) begin
          w1_q  <= w1_new;
          hit_q <= 1'b1;
          st    <= (w1_new != mem_rdata) ? W_WBACK : W_FIN;
        end
        W_WBACK: if (mem_ack) st <= W_FIN;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == W_RD_HI) || (st == W_RD_LO) || (st == W_WBACK);
  assign mem_we    = (st == W_WBACK);
  assign mem_addr  = (st == W_RD_HI) ? ent_addr : addr_q + 32'(LO_OFS);
  assign mem_wdata = w1_q;
  assign done      = (st == W_FIN);
  assign hit       = hit_q;
  assign pte_hi    = w0_q;
  assign pte_lo    = w1_q;
  assign pte_addr  = addr_q;
  assign phys_addr = {w1_q[31:PIDX_LSB], ea_q[PIDX_LSB-1:0]};
  assign wr_keep   = hit_q && store_q;

  // R10: a raised request holds its fields until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R3: second word is fetched only behind a matching first word
  a_r3_lo_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_addr == pte_addr + 32'(LO_OFS) && st == W_RD_LO) |-> w0_q[B_VALID]);
  // R5: a miss comes only out of the secondary pass
  a_r5_miss_late: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> sec_pass);
  // R6: any write-back carries the referenced bit, and changed for a store
  a_r6_wb_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[B_REF] && (!store_q || mem_wdata[B_CHG])));
  // R7: a write-back follows only a second-word read that changed
  a_r7_wb_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> ($past(rd_lo_ack) && ($past(mem_rdata) != mem_wdata)));
  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: a hit result always reports the referenced bit
  a_r6_hit_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> pte_lo[B_REF]);
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] MASK = 32'h0000_0FC0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_store = 1'b0;
  logic [31:0] seg_reg = '0, ea = '0;
  logic mem_req, mem_we, mem_ack = 1'b0, done, hit, wr_keep;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, pte_hi, pte_lo, pte_addr, phys_addr;

  int checks = 0, fails = 0, cyc = 0;
  int n_hi_rd = 0, n_lo_rd = 0, n_wr = 0, instab = 0;
  logic [31:0] mem [0:1023];

  always #4 clk = ~clk;

  hpt_walker u0 (.clk(clk), .rst_n(rst_n), .start(start), .seg_reg(seg_reg), .ea(ea),
    .is_store(is_store), .tbl_base(BASE), .tbl_mask(MASK), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .hit(hit), .pte_hi(pte_hi), .pte_lo(pte_lo),
    .pte_addr(pte_addr), .phys_addr(phys_addr), .wr_keep(wr_keep));

  function automatic int widx(input logic [31:0] a);
    return int'((a - BASE) >> 2) & 1023;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder with random latency
  bit pend = 0; int wcnt = 0;
  logic [31:0] l_addr, l_data; logic l_we;
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (rst_n && mem_req) begin
      if (!pend) begin
        pend = 1; l_addr = mem_addr; l_we = mem_we; l_data = mem_wdata;
        wcnt = int'($urandom % 3);
      end else if (mem_addr != l_addr || mem_we != l_we || mem_wdata != l_data) instab++;
      if (wcnt == 0) begin
        if (l_we) begin mem[widx(l_addr)] = l_data; n_wr++; end
        else begin
          mem_rdata = mem[widx(l_addr)];
          if (l_addr[2]) n_lo_rd++; else n_hi_rd++;
        end
        mem_ack = 1'b1; pend = 0;
      end else wcnt--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL R11 watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // independent reference walk on the current memory image
  task automatic ref_walk(input logic [31:0] s, input logic [31:0] e,
      output bit fnd, output logic [31:0] a, output int reads);
    logic [31:0] vsid, h, g, w;
    vsid = s & 32'h00FF_FFFF; fnd = 0; a = 0; reads = 0;
    for (int p = 0; p < 2 && !fnd; p++) begin
      h = vsid ^ ((e >> 12) & 32'hFFFF);
      if (p == 1) h = ~h;
      g = BASE + ((h * 64) & MASK);
      for (int i = 0; i < 8 && !fnd; i++) begin
        w = mem[widx(g + 8*i)]; reads++;
        if (w[31] && (w[6] == p[0]) && (((w >> 7) & 32'hFF_FFFF) == vsid)
            && ((w & 63) == ((e >> 22) & 63))) begin fnd = 1; a = g + 8*i; end
      end
    end
  endtask

  function automatic logic [31:0] slot_addr(input logic [31:0] s, input logic [31:0] e,
      input int p, input int i);
    logic [31:0] h;
    h = (s & 32'hFF_FFFF) ^ ((e >> 12) & 32'hFFFF);
    if (p == 1) h = ~h;
    return BASE + ((h * 64) & MASK) + 8*i;
  endfunction

  function automatic logic [31:0] mk_w0(input logic [31:0] s, input logic [31:0] e, input int p);
    return 32'h8000_0000 | ((s & 32'hFF_FFFF) << 7) | (p[0] ? 32'h40 : 32'h0) | ((e >> 22) & 63);
  endfunction

  task automatic fill_junk();
    for (int k = 0; k < 1024; k++) mem[k] = $urandom;
  endtask

  task automatic run_walk(input logic [31:0] s, input logic [31:0] e, input bit stv, input string tag);
    bit fnd; logic [31:0] a, w0e, w1o, w1e; int rd, to;
    ref_walk(s, e, fnd, a, rd);
    w0e = fnd ? mem[widx(a)] : 0; w1o = fnd ? mem[widx(a + 4)] : 0;
    w1e = w1o | 32'h100 | (stv ? 32'h80 : 32'h0);
    n_hi_rd = 0; n_lo_rd = 0; n_wr = 0; instab = 0;
    @(negedge clk); seg_reg = s; ea = e; is_store = stv; start = 1'b1;
    @(negedge clk); start = 1'b0;
    to = 0;
    while (!done && to < 2000) begin @(negedge clk); to++; end
    chk(done == 1'b1, {"R11 done ", tag}, {31'b0, done}, 32'h1);
    chk(hit == fnd, {"R4 R5 hit ", tag}, {31'b0, hit}, {31'b0, fnd});
    chk(n_hi_rd == rd, {"R3 R5 first-word reads ", tag}, n_hi_rd, rd);
    chk(n_lo_rd == (fnd ? 1 : 0), {"R3 second-word reads ", tag}, n_lo_rd, fnd);
    chk(instab == 0, {"R10 request stable ", tag}, instab, 0);
    if (fnd) begin
      chk(pte_addr == a, {"R1 R2 R8 pte_addr ", tag}, pte_addr, a);
      chk(pte_hi == w0e, {"R8 pte_hi ", tag}, pte_hi, w0e);
      chk(pte_lo == w1e, {"R6 pte_lo ", tag}, pte_lo, w1e);
      chk(phys_addr == {w1e[31:12], e[11:0]}, {"R8 phys ", tag}, phys_addr, {w1e[31:12], e[11:0]});
      chk(wr_keep == stv, {"R9 wr_keep ", tag}, {31'b0, wr_keep}, {31'b0, stv});
      chk(n_wr == ((w1e != w1o) ? 1 : 0), {"R7 write count ", tag}, n_wr, (w1e != w1o));
      chk(mem[widx(a + 4)] == w1e, {"R7 memory word ", tag}, mem[widx(a + 4)], w1e);
    end else chk(n_wr == 0, {"R7 no write on miss ", tag}, n_wr, 0);
    @(negedge clk);
    chk(done == 1'b0, {"R11 done pulse ", tag}, {31'b0, done}, 0);
    chk(hit == fnd, {"R11 result held ", tag}, {31'b0, hit}, {31'b0, fnd});
  endtask

  initial begin
    logic [31:0] s, e, a;
    int mode, slot;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_req == 0, "R11 reset state", {30'b0, done, mem_req}, 0);
    rst_n = 1'b1;

    // directed: match in primary slot 7 plus a secondary match
    fill_junk(); s = 32'h00AB_CDEF; e = 32'h1234_5678;
    a = slot_addr(s, e, 0, 7); mem[widx(a)] = mk_w0(s, e, 0); mem[widx(a + 4)] = 32'h5555_5000;
    a = slot_addr(s, e, 1, 0); mem[widx(a)] = mk_w0(s, e, 1);
    for (int i = 0; i < 7; i++) mem[widx(slot_addr(s, e, 0, i))] = 32'h0;
    run_walk(s, e, 1'b0, "primary slot7 vs rollover");
    chk(pte_addr == slot_addr(s, e, 0, 7), "R5 primary wins", pte_addr, slot_addr(s, e, 0, 7));

    // directed: bits already set, no write-back
    a = slot_addr(s, e, 0, 7); mem[widx(a + 4)] = 32'h7777_7180;
    run_walk(s, e, 1'b1, "store RC already set");
    mem[widx(a + 4)] = 32'h7777_7100;
    run_walk(s, e, 1'b0, "load R already set");

    // directed: wrong hash-select in primary, real entry secondary slot 3
    fill_junk(); s = 32'h0000_0011; e = 32'hFFFF_F123;
    for (int i = 0; i < 8; i++) mem[widx(slot_addr(s, e, 0, i))] = 32'h0;
    mem[widx(slot_addr(s, e, 0, 2))] = mk_w0(s, e, 1);
    mem[widx(slot_addr(s, e, 1, 3))] = mk_w0(s, e, 1);
    run_walk(s, e, 1'b1, "secondary via R4 hsel");

    // directed: full miss
    fill_junk();
    for (int p = 0; p < 2; p++) for (int i = 0; i < 8; i++) mem[widx(slot_addr(s, e, p, i))] = 32'h0;
    run_walk(s, e, 1'b0, "full miss");

    // constrained random
    for (int t = 0; t < 200; t++) begin
      fill_junk();
      s = $urandom; e = $urandom; mode = int'($urandom % 3); slot = int'($urandom % 8);
      if (mode != 0) begin
        a = slot_addr(s, e, mode - 1, slot);
        mem[widx(a)] = mk_w0(s, e, mode - 1);
      end
      run_walk(s, e, $urandom % 2 == 1, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule